// File: doc/BRIEF.md
# Lockable GPIO Register Bank

This block is the register layer of a 32-pin general purpose I/O controller. It takes simple word accesses from a bus (write strobe, read strobe, byte address, access size, write data) and holds the per-pin configuration that the pin and event logic downstream consume. That configuration covers output level, output enable, polarity, open-drain type, pulls, input masking, event type, both-edge selection and event enables. A read returns the addressed register in the same cycle. A write takes effect at the next clock edge.

Software can update output data and output enables bit by bit through set and clear alias words, so it never needs a read-modify-write. Event-status bits are raised by the event logic through a hit vector and are cleared by writing ones. A global write lock freezes the whole configuration. A write of any value to either of the two key words engages it. Only a two-step key sequence releases it: first a specific word is written to the second key register, then a specific word is written to the first.

Top module: `gpio_lockreg_bank`

## Requirements
- R1: After reset every register reads 0. The exceptions are pull-up (0x1C), pull-down (0x20), slew (0x5C) and drive-strength (0x60), which hold their parameter reset values. The bank comes out of reset unlocked.
- R2: Writing polarity 0x08, data-out 0x0C, output-enable 0x10, output-type 0x14, pull-up 0x1C, pull-down 0x20, event-type 0x28, both-edge 0x2C, event-enable 0x40 or input-mask 0x58 stores the value. The matching output port shows it from the cycle after the write, and a read returns it.
- R3: Alias words act on their target as follows. 0x68 ORs the written value into data-out and 0x6C clears the written ones from data-out. 0x70 and 0x74 do the same to output-enable. Reads of all four return 0.
- R4: Each 1 on evt_hit_i sets the matching event-status bit (0x4C) at the next edge. Writing 0x4C clears each bit written as 1, but a hit in the same cycle wins. Word 0x44 ORs into event-enable and 0x48 clears bits of it.
- R5: Reading 0x04 returns din_i, and writes to 0x04 are ignored.
- R6: While unlocked, a write of any value to 0x00 or 0x7C engages the lock. After that, 0x00 reads 1.
- R7: While locked, writes to every offset other than 0x00 and 0x7C have no effect.
- R8: While locked, a write to 0x7C stores the key. A write of UNLOCK_KEY1 (default 0xC0DEFA73) to 0x00 releases the lock only if the stored key equals UNLOCK_KEY2 (default 0xC0DE1248). Releasing clears the stored key. Reads of 0x7C always return 0.
- R9: An access whose size code is not 2 (4 bytes), or whose address has bits [1:0] not zero, is ignored. A write to it changes nothing, and a read of it returns 0.
- R10: Reads of the per-pin lock words 0x50 and 0x54, of unassigned offsets 0x64, 0x78 and 0x80 upward, all return 0. Writes to them change nothing.
- R11: Multiplex 0x18, debounce 0x24, blink 0x30 to 0x3C, slew 0x5C and drive-strength 0x60 are storage only, and read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one access per asserted cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (12) | Byte address |
| bus_size | input | 2 | log2 of access bytes; only 2 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| din_i | input | NP (32) | Pin input value presented at the data-in word |
| evt_hit_i | input | NP (32) | Event detections that set status bits |
| pol_o | output | NP | Polarity |
| dout_o | output | NP | Output data |
| oe_o | output | NP | Output enable |
| otyp_o | output | NP | Open-drain type select |
| pu_o | output | NP | Pull-up enable |
| pd_o | output | NP | Pull-down enable |
| iem_o | output | NP | Input enable mask |
| evtyp_o | output | NP | Event type (edge vs level) |
| evbe_o | output | NP | Both-edge select |
| even_o | output | NP | Event enable |

## Verification
The lock gets the most attention. The bench engages it through each key word. It then tries to release it with the right first key but a missing second key, with a wrong second key, and with a wrong first key after a correct second key. A design that matched only one key, or that lost the stored key on a failed attempt, would unlock too early or never unlock. While the bank is locked, the bench writes data-out and checks the output port, which catches a lock that only blocks reads or only some offsets. A write that clears event status and a new hit in the same cycle are raised together, and the bench expects the hit to survive; a design that let the clear win would drop an event. Misaligned and narrow accesses are aimed at live registers, so a decoder that ignored the low address bits or the size code would corrupt data-out.

// File: rtl/gpio_lk_pkg.sv
package gpio_lk_pkg;

    localparam int IDXW = 5;

    // Word indices; the order is the software-visible layout.
    localparam logic [IDXW-1:0] IX_LOCK1    = 5'd0;
    localparam logic [IDXW-1:0] IX_DIN      = 5'd1;
    localparam logic [IDXW-1:0] IX_POL      = 5'd2;
    localparam logic [IDXW-1:0] IX_DOUT     = 5'd3;
    localparam logic [IDXW-1:0] IX_OE       = 5'd4;
    localparam logic [IDXW-1:0] IX_OTYP     = 5'd5;
    localparam logic [IDXW-1:0] IX_MUX      = 5'd6;
    localparam logic [IDXW-1:0] IX_PU       = 5'd7;
    localparam logic [IDXW-1:0] IX_PD       = 5'd8;
    localparam logic [IDXW-1:0] IX_DBNC     = 5'd9;
    localparam logic [IDXW-1:0] IX_EVTYP    = 5'd10;
    localparam logic [IDXW-1:0] IX_EVBE     = 5'd11;
    localparam logic [IDXW-1:0] IX_BLINK0   = 5'd12;
    localparam logic [IDXW-1:0] IX_BLINK3   = 5'd15;
    localparam logic [IDXW-1:0] IX_EVEN     = 5'd16;
    localparam logic [IDXW-1:0] IX_EVEN_SET = 5'd17;
    localparam logic [IDXW-1:0] IX_EVEN_CLR = 5'd18;
    localparam logic [IDXW-1:0] IX_EVST     = 5'd19;
    localparam logic [IDXW-1:0] IX_IEM      = 5'd22;
    localparam logic [IDXW-1:0] IX_SLEW     = 5'd23;
    localparam logic [IDXW-1:0] IX_DRIVE    = 5'd24;
    localparam logic [IDXW-1:0] IX_DOUT_SET = 5'd26;
    localparam logic [IDXW-1:0] IX_DOUT_CLR = 5'd27;
    localparam logic [IDXW-1:0] IX_OE_SET   = 5'd28;
    localparam logic [IDXW-1:0] IX_OE_CLR   = 5'd29;
    localparam logic [IDXW-1:0] IX_LOCK2    = 5'd31;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef struct packed {
        logic locked;
        logic key_ok;   // second key register holds the release word
    } lock_st_t;

endpackage

// File: rtl/gpio_lk_dec.sv
module gpio_lk_dec
    import gpio_lk_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [AW-1:0]   addr,
    input  logic [1:0]      size,
    output logic            hit,
    output logic [IDXW-1:0] widx
);
    localparam int TOPB = IDXW + 2;

    logic aligned;
    logic in_win;

    assign aligned = (size == SIZE_WORD) && (addr[1:0] == 2'b00);
    assign in_win  = (addr >> TOPB) == '0;
    assign hit     = aligned && in_win;
    assign widx    = addr[TOPB-1:2];
endmodule

// File: rtl/gpio_lk_lock.sv
module gpio_lk_lock
    import gpio_lk_pkg::*;
#(
    parameter logic [31:0] KEY1 = 32'hC0DE_FA73,
    parameter logic [31:0] KEY2 = 32'hC0DE_1248
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ok,
    input  logic [IDXW-1:0] widx,
    input  logic [31:0]     wdata,
    output logic            locked
);
    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            if (st_q.locked) begin
                if (widx == IX_LOCK2) begin
                    st_d.key_ok = (wdata == KEY2);
                end else if (widx == IX_LOCK1 && st_q.key_ok && wdata == KEY1) begin
                    st_d.locked = 1'b0;
                    st_d.key_ok = 1'b0;
                end
            end else if (widx == IX_LOCK1 || widx == IX_LOCK2) begin
                st_d.locked = 1'b1;
                st_d.key_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;
endmodule

// File: rtl/gpio_lockreg_bank.sv
module gpio_lockreg_bank
    import gpio_lk_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          NP        = 32,
    parameter logic [31:0] RST_PU    = 32'h0,
    parameter logic [31:0] RST_PD    = 32'h0,
    parameter logic [31:0] RST_SLEW  = 32'h0,
    parameter logic [31:0] RST_DRIVE = 32'h0,
    parameter logic [31:0] KEY1      = 32'hC0DE_FA73,
    parameter logic [31:0] KEY2      = 32'hC0DE_1248
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_size,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [NP-1:0] din_i,
    input  logic [NP-1:0] evt_hit_i,
    output logic [NP-1:0] pol_o,
    output logic [NP-1:0] dout_o,
    output logic [NP-1:0] oe_o,
    output logic [NP-1:0] otyp_o,
    output logic [NP-1:0] pu_o,
    output logic [NP-1:0] pd_o,
    output logic [NP-1:0] iem_o,
    output logic [NP-1:0] evtyp_o,
    output logic [NP-1:0] evbe_o,
    output logic [NP-1:0] even_o
);
    localparam int NBLINK = 4;

    typedef struct packed {
        logic [NP-1:0] pol, dout, oe, otyp, mux, pu, pd, dbnc;
        logic [NP-1:0] evtyp, evbe, even, evst, iem, slew, drive;
        logic [NBLINK-1:0][NP-1:0] blink;
    } regs_t;

    regs_t           cur_q, nxt_d;
    logic            hit;
    logic [IDXW-1:0] widx;
    logic            locked;
    logic            wr_go;
    logic [NP-1:0]   wv;
    logic [NP-1:0]   st_clr;
    logic [NP-1:0]   evst_cur;
    logic [31:0]     rv;

    gpio_lk_dec #(.AW(AW)) dec_i (
        .addr (bus_addr),
        .size (bus_size),
        .hit  (hit),
        .widx (widx)
    );

    gpio_lk_lock #(.KEY1(KEY1), .KEY2(KEY2)) lock_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ok  (bus_wr && hit),
        .widx   (widx),
        .wdata  (bus_wdata),
        .locked (locked)
    );

    assign wr_go    = bus_wr && hit && !locked;
    assign wv       = bus_wdata[NP-1:0];
    assign evst_cur = cur_q.evst;

    always_comb begin
        nxt_d  = cur_q;
        st_clr = '0;
        if (wr_go) begin
            case (widx)
                IX_POL:      nxt_d.pol   = wv;
                IX_DOUT:     nxt_d.dout  = wv;
                IX_OE:       nxt_d.oe    = wv;
                IX_OTYP:     nxt_d.otyp  = wv;
                IX_MUX:      nxt_d.mux   = wv;
                IX_PU:       nxt_d.pu    = wv;
                IX_PD:       nxt_d.pd    = wv;
                IX_DBNC:     nxt_d.dbnc  = wv;
                IX_EVTYP:    nxt_d.evtyp = wv;
                IX_EVBE:     nxt_d.evbe  = wv;
                IX_EVEN:     nxt_d.even  = wv;
                IX_EVEN_SET: nxt_d.even  = cur_q.even | wv;
                IX_EVEN_CLR: nxt_d.even  = cur_q.even & ~wv;
                IX_EVST:     st_clr      = wv;
                IX_IEM:      nxt_d.iem   = wv;
                IX_SLEW:     nxt_d.slew  = wv;
                IX_DRIVE:    nxt_d.drive = wv;
                IX_DOUT_SET: nxt_d.dout  = cur_q.dout | wv;
                IX_DOUT_CLR: nxt_d.dout  = cur_q.dout & ~wv;
                IX_OE_SET:   nxt_d.oe    = cur_q.oe | wv;
                IX_OE_CLR:   nxt_d.oe    = cur_q.oe & ~wv;
                default: begin
                    for (int b = 0; b < NBLINK; b++) begin
                        if (widx == IX_BLINK0 + IDXW'(b)) nxt_d.blink[b] = wv;
                    end
                end
            endcase
        end
        // a fresh detection outranks a software clear of the same bit
        nxt_d.evst = (cur_q.evst & ~st_clr) | evt_hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.pu    <= RST_PU[NP-1:0];
            cur_q.pd    <= RST_PD[NP-1:0];
            cur_q.slew  <= RST_SLEW[NP-1:0];
            cur_q.drive <= RST_DRIVE[NP-1:0];
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        rv = '0;
        if (bus_rd && hit) begin
            case (widx)
                IX_LOCK1: rv = 32'(locked);
                IX_DIN:   rv = 32'(din_i);
                IX_POL:   rv = 32'(cur_q.pol);
                IX_DOUT:  rv = 32'(cur_q.dout);
                IX_OE:    rv = 32'(cur_q.oe);
                IX_OTYP:  rv = 32'(cur_q.otyp);
                IX_MUX:   rv = 32'(cur_q.mux);
                IX_PU:    rv = 32'(cur_q.pu);
                IX_PD:    rv = 32'(cur_q.pd);
                IX_DBNC:  rv = 32'(cur_q.dbnc);
                IX_EVTYP: rv = 32'(cur_q.evtyp);
                IX_EVBE:  rv = 32'(cur_q.evbe);
                IX_EVEN:  rv = 32'(cur_q.even);
                IX_EVST:  rv = 32'(cur_q.evst);
                IX_IEM:   rv = 32'(cur_q.iem);
                IX_SLEW:  rv = 32'(cur_q.slew);
                IX_DRIVE: rv = 32'(cur_q.drive);
                default: begin
                    for (int b = 0; b < NBLINK; b++) begin
                        if (widx == IX_BLINK0 + IDXW'(b)) rv = 32'(cur_q.blink[b]);
                    end
                end
            endcase
        end
    end

    assign bus_rdata = rv;
    assign pol_o     = cur_q.pol;
    assign dout_o    = cur_q.dout;
    assign oe_o      = cur_q.oe;
    assign otyp_o    = cur_q.otyp;
    assign pu_o      = cur_q.pu;
    assign pd_o      = cur_q.pd;
    assign iem_o     = cur_q.iem;
    assign evtyp_o   = cur_q.evtyp;
    assign evbe_o    = cur_q.evbe;
    assign even_o    = cur_q.even;
endmodule

// File: rtl/gpio_lockreg_bank_chk.sv
module gpio_lockreg_bank_chk #(
    parameter int AW = 12,
    parameter int NP = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [1:0]    bus_size,
    input logic [31:0]   bus_rdata,
    input logic [NP-1:0] dout_o,
    input logic [NP-1:0] oe_o,
    input logic [NP-1:0] evt_hit_i,
    input logic          lock_st,
    input logic [NP-1:0] evst_st
);
    logic word_acc;
    assign word_acc = (bus_size == 2'd2) && (bus_addr[1:0] == 2'b00) && ((bus_addr >> 7) == '0);

    AST_LOCK_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && word_acc && !lock_st && (bus_addr[6:2] == 5'd0 || bus_addr[6:2] == 5'd31)
        |=> lock_st); // R6

    AST_LOCKED_DOUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock_st && bus_wr && bus_addr[6:2] != 5'd0 && bus_addr[6:2] != 5'd31
        |=> $stable(dout_o) && $stable(oe_o)); // R7

    AST_EVT_HIT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        |evt_hit_i |=> ((evst_st & $past(evt_hit_i)) == $past(evt_hit_i))); // R4

    AST_BAD_ACCESS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !word_acc |=> $stable(dout_o) && $stable(oe_o) && $stable(lock_st)); // R9

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !word_acc |-> bus_rdata == 32'h0); // R9

    AST_KEY2_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && word_acc && bus_addr[6:2] == 5'd31 |-> bus_rdata == 32'h0); // R8

    AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && word_acc && bus_addr[6:2] >= 5'd26 && bus_addr[6:2] <= 5'd29
        |-> bus_rdata == 32'h0); // R3
endmodule

bind gpio_lockreg_bank gpio_lockreg_bank_chk #(.AW(AW), .NP(NP)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_rdata (bus_rdata),
    .dout_o    (dout_o),
    .oe_o      (oe_o),
    .evt_hit_i (evt_hit_i),
    .lock_st   (locked),
    .evst_st   (evst_cur)
);

// File: tb/gpio_lockreg_bank_tb.sv
module gpio_lockreg_bank_tb_top;
    localparam int          AW = 12;
    localparam int          NP = 32;
    localparam logic [31:0] P_PU    = 32'h0000_FF00;
    localparam logic [31:0] P_PD    = 32'h00FF_0000;
    localparam logic [31:0] P_SLEW  = 32'h1234_5678;
    localparam logic [31:0] P_DRIVE = 32'h8765_4321;
    localparam logic [31:0] K1 = 32'hC0DE_FA73;
    localparam logic [31:0] K2 = 32'hC0DE_1248;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'd2;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] din_i = '0, evt_hit_i = '0;
    logic [NP-1:0] pol_o, dout_o, oe_o, otyp_o, pu_o, pd_o, iem_o, evtyp_o, evbe_o, even_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_lockreg_bank #(
        .AW(AW), .NP(NP), .RST_PU(P_PU), .RST_PD(P_PD),
        .RST_SLEW(P_SLEW), .RST_DRIVE(P_DRIVE), .KEY1(K1), .KEY2(K2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .din_i(din_i), .evt_hit_i(evt_hit_i),
        .pol_o(pol_o), .dout_o(dout_o), .oe_o(oe_o), .otyp_o(otyp_o),
        .pu_o(pu_o), .pd_o(pd_o), .iem_o(iem_o), .evtyp_o(evtyp_o),
        .evbe_o(evbe_o), .even_o(even_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_wr = 1'b0; bus_size = 2'd2;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_size = sz;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_size = 2'd2;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pu", pu_o, P_PU);
        chk("R1 pd", pd_o, P_PD);
        chk("R1 dout", dout_o, 0);
        chk("R1 oe", oe_o, 0);
        rd(12'h05C, v); chk("R1 slew", v, P_SLEW);
        rd(12'h060, v); chk("R1 drive", v, P_DRIVE);
        rd(12'h000, v); chk("R1 unlocked", v, 0);
        rd(12'h04C, v); chk("R1 evst", v, 0);
    endtask

    task automatic t_plain();
        logic [31:0] v;
        wr(12'h00C, 32'hA5A5_3C3C); chk("R2 dout port", dout_o, 32'hA5A5_3C3C);
        rd(12'h00C, v);             chk("R2 dout read", v, 32'hA5A5_3C3C);
        wr(12'h008, 32'h0F0F_0000); chk("R2 pol port", pol_o, 32'h0F0F_0000);
        wr(12'h058, 32'hFFFF_0001); chk("R2 iem port", iem_o, 32'hFFFF_0001);
        wr(12'h02C, 32'h0000_0088); chk("R2 evbe port", evbe_o, 32'h0000_0088);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(12'h00C, 32'h0000_00F0);
        wr(12'h068, 32'h0000_000F); chk("R3 dout set", dout_o, 32'h0000_00FF);
        wr(12'h06C, 32'h0000_0030); chk("R3 dout clr", dout_o, 32'h0000_00CF);
        wr(12'h010, 32'h0);
        wr(12'h070, 32'h0000_0003); chk("R3 oe set", oe_o, 32'h3);
        wr(12'h074, 32'h0000_0001); chk("R3 oe clr", oe_o, 32'h2);
        rd(12'h068, v); chk("R3 alias read", v, 0);
        rd(12'h074, v); chk("R3 alias read", v, 0);
    endtask

    task automatic t_din();
        logic [31:0] v;
        din_i = 32'hDEAD_BEEF;
        rd(12'h004, v); chk("R5 din read", v, 32'hDEAD_BEEF);
        wr(12'h004, 32'h0);
        rd(12'h004, v); chk("R5 din write ignored", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_event();
        logic [31:0] v;
        wr(12'h040, 32'h1);
        wr(12'h044, 32'h6); chk("R4 even set", even_o, 32'h7);
        wr(12'h048, 32'h2); chk("R4 even clr", even_o, 32'h5);
        @(negedge clk); evt_hit_i = 32'h0000_000F;
        @(negedge clk); evt_hit_i = '0;
        rd(12'h04C, v); chk("R4 evst set", v, 32'hF);
        wr(12'h04C, 32'h3);
        rd(12'h04C, v); chk("R4 evst w1c", v, 32'hC);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h04C; bus_wdata = 32'hC; evt_hit_i = 32'h4;
        @(negedge clk);
        bus_wr = 1'b0; evt_hit_i = '0;
        rd(12'h04C, v); chk("R4 hit beats clear", v, 32'h4);
    endtask

    task automatic t_stored();
        logic [31:0] v;
        wr(12'h018, 32'h1111_2222); rd(12'h018, v); chk("R11 mux", v, 32'h1111_2222);
        wr(12'h024, 32'h3333_4444); rd(12'h024, v); chk("R11 debounce", v, 32'h3333_4444);
        wr(12'h030, 32'h5555_6666); rd(12'h030, v); chk("R11 blink0", v, 32'h5555_6666);
        wr(12'h03C, 32'h7777_8888); rd(12'h03C, v); chk("R11 blink3", v, 32'h7777_8888);
        wr(12'h05C, 32'h9999_AAAA); rd(12'h05C, v); chk("R11 slew", v, 32'h9999_AAAA);
    endtask

    task automatic t_bus();
        logic [31:0] v;
        wr(12'h00C, 32'h0000_1234);
        wr(12'h00D, 32'hFFFF_FFFF);       chk("R9 misaligned write", dout_o, 32'h1234);
        wr(12'h00C, 32'hFFFF_FFFF, 2'd1); chk("R9 narrow write", dout_o, 32'h1234);
        rd(12'h00E, v);                   chk("R9 misaligned read", v, 0);
        rd(12'h00C, v, 2'd0);             chk("R9 narrow read", v, 0);
        rd(12'h080, v);                   chk("R10 undecoded read", v, 0);
        rd(12'h064, v);                   chk("R10 hole read", v, 0);
        wr(12'h050, 32'hFFFF_FFFF);
        rd(12'h050, v);                   chk("R10 pin lock ignored", v, 0);
        wr(12'h08C, 32'hFFFF_FFFF);       chk("R10 alias beyond window", dout_o, 32'h1234);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(12'h07C, 32'h0000_1234);
        rd(12'h000, v); chk("R6 engage via key2", v, 1);
        rd(12'h07C, v); chk("R8 key2 reads 0", v, 0);
        wr(12'h00C, 32'h0);          chk("R7 dout frozen", dout_o, 32'h1234);
        wr(12'h070, 32'hFF);         chk("R7 oe frozen", oe_o, 32'h2);
        wr(12'h000, K1);
        rd(12'h000, v); chk("R8 key1 without key2", v, 1);
        wr(12'h07C, 32'hC0DE_0000);
        wr(12'h000, K1);
        rd(12'h000, v); chk("R8 wrong key2", v, 1);
        wr(12'h07C, K2);
        rd(12'h07C, v); chk("R8 key2 reads 0 after key", v, 0);
        wr(12'h000, 32'h0);
        rd(12'h000, v); chk("R8 wrong key1", v, 1);
        wr(12'h000, K1);
        rd(12'h000, v); chk("R8 released", v, 0);
        wr(12'h00C, 32'h0000_5678); chk("R8 writes after release", dout_o, 32'h5678);
        wr(12'h000, 32'h0);
        rd(12'h000, v); chk("R6 engage via key1", v, 1);
        wr(12'h000, K1);
        rd(12'h000, v); chk("R8 key cleared by release", v, 1);
        wr(12'h07C, K2); wr(12'h000, K1);
        rd(12'h000, v); chk("R8 second release", v, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_alias();
        t_din();
        t_event();
        t_stored();
        t_bus();
        t_lock();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule